// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block is the core-facing side of an interrupt controller for one processor. A distributor hands it a single best candidate: an interrupt ID, its 8-bit priority and, for software-generated interrupts, the number of the CPU that raised it. The block decides whether that candidate may interrupt the core right now. It then drives one level-sensitive request line and offers four word registers to the core.

The block tests each candidate against a global enable, a programmable priority threshold and the priority of the interrupts already being serviced. It keeps the serviced interrupts on a small running-priority stack. Reading the acknowledge register claims the candidate. The read returns a packed word, pushes the interrupt onto the stack and sends a one-cycle acknowledge pulse back to the distributor, so that the distributor can clear an edge-type pending bit or hold a level-type source. Writing the same packed word to the end-of-interrupt register retires the matching active entry and sends a retire pulse to the distributor. A lower priority value is more urgent. Lower-priority work may therefore be pre-empted, up to the stack depth.

Top module: `cpuif_ack_unit`

## Requirements
- R1: A successful acknowledge read returns the interrupt ID in bits 9:0. For IDs 0 to 15 it also returns the requesting CPU number in bits 12:10. For IDs 16 and above, bits 12:10 are zero. All other bits are always zero.
- R2: When no candidate qualifies, an acknowledge read returns 1023. The read pushes nothing, emits no acknowledge pulse and leaves the request line unchanged.
- R3: A candidate whose ID is above 1019 never qualifies. The read-back ID field never holds 1020, 1021 or 1022.
- R4: A candidate qualifies only if its priority value is strictly below the 8-bit priority mask. A value equal to the mask is not signalled.
- R5: Bit 0 of the control register (select 0) enables signalling. While it is 0, irq_o is low and an acknowledge read returns 1023.
- R6: A candidate qualifies only if its priority value is strictly below the running priority. The running priority is that of the most recent active entry, or above every 8-bit value when no entry is active. A successful acknowledge pulses ack_valid_o for one cycle, and in that cycle irq_o is low.
- R7: Writing an ID to the end-of-interrupt register (select 3) retires the most recent active entry with that ID. For IDs 0 to 15 the CPU number in bits 12:10 must also match. The write pulses eoi_valid_o for one cycle, and the running priority falls back to the entry below.
- R8: An end-of-interrupt write that matches no active entry changes no state and emits no retire pulse.
- R9: While STACK_DEPTH entries are active, no further candidate is signalled or acknowledged.
- R10: Select 0 reads back the enable in bit 0, and select 1 reads back the mask in bits 7:0. Select 2 is the acknowledge register and select 3 is the end-of-interrupt register. Read data appears in the cycle after the read and is zero in any other cycle.
- R11: After reset the enable is 0, the mask is 0, no entry is active, and irq_o, ack_valid_o and eoi_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cand_valid_i | input | 1 | Distributor presents a candidate |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_prio_i | input | 8 | Candidate priority value (lower is more urgent) |
| cand_src_i | input | 3 | Requesting CPU for IDs 0 to 15 |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 control, 1 mask, 2 acknowledge, 3 end of interrupt) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Interrupt request to the core |
| ack_valid_o | output | 1 | Acknowledge pulse to the distributor |
| ack_id_o | output | 10 | Acknowledged ID |
| ack_src_o | output | 3 | Acknowledged requesting CPU |
| eoi_valid_o | output | 1 | Retire pulse to the distributor |
| eoi_id_o | output | 10 | Retired ID |
| eoi_src_o | output | 3 | Retired requesting CPU |

## Verification
Directed sequences place the candidate priority exactly at the mask and one below it, which separates a strict compare from an inclusive one. They also present reserved IDs and toggle the enable bit. Nested acknowledges with falling priorities fill the stack to its depth and show whether the running priority, rather than the mask alone, gates the line. End-of-interrupt writes with a wrong ID, or a wrong CPU number on a software-generated ID, are told apart from correct ones by the retire pulse and by the later request line. A long seeded random mix of candidates, reads, retires and mask changes is compared cycle by cycle against a reference stack model in the bench.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

    localparam int ID_W      = 10;
    localparam int SRC_W     = 3;
    localparam int PRIO_W    = 8;
    localparam int DATA_W    = 32;
    localparam int SGI_COUNT = 16;

    localparam logic [ID_W-1:0]   MAX_VALID_ID = ID_W'(1019);
    localparam logic [ID_W-1:0]   SPURIOUS_ID  = ID_W'(1023);
    localparam logic [PRIO_W:0]   IDLE_PRIO    = {1'b1, {PRIO_W{1'b0}}};

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_PMASK = 2'd1,
        SEL_ACK   = 2'd2,
        SEL_EOI   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [SRC_W-1:0]  src;
        logic [PRIO_W-1:0] prio;
    } act_entry_t;

    typedef struct packed {
        logic              en;
        logic [PRIO_W-1:0] pmask;
        logic              irq;
        logic [DATA_W-1:0] rdata;
        logic              ack_v;
        logic [ID_W-1:0]   ack_id;
        logic [SRC_W-1:0]  ack_src;
        logic              eoi_v;
        logic [ID_W-1:0]   eoi_id;
        logic [SRC_W-1:0]  eoi_src;
    } unit_state_t;

    function automatic logic is_sgi(input logic [ID_W-1:0] id);
        return id < ID_W'(SGI_COUNT);
    endfunction

endpackage

// File: rtl/cpuif_qualify.sv
module cpuif_qualify
    import cpuif_pkg::*;
(
    input  logic              en_i,
    input  logic [PRIO_W-1:0] pmask_i,
    input  logic [PRIO_W:0]   run_prio_i,
    input  logic              full_i,
    input  logic              cand_valid_i,
    input  logic [ID_W-1:0]   cand_id_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    output logic              signal_o
);

    logic id_ok;
    logic mask_ok;
    logic run_ok;

    always_comb begin
        id_ok    = cand_id_i <= MAX_VALID_ID;
        mask_ok  = cand_prio_i < pmask_i;
        run_ok   = {1'b0, cand_prio_i} < run_prio_i;
        signal_o = en_i && cand_valid_i && !full_i && id_ok && mask_ok && run_ok;
    end

endmodule

// File: rtl/cpuif_active_stack.sv
module cpuif_active_stack
    import cpuif_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  act_entry_t        push_entry_i,
    input  logic              eoi_i,
    input  logic [ID_W-1:0]   eoi_id_i,
    input  logic [SRC_W-1:0]  eoi_src_i,
    output logic              eoi_hit_o,
    output logic [PRIO_W:0]   run_prio_o,
    output logic [PRIO_W:0]   run_prio_nxt_o,
    output logic              full_o,
    output logic              full_nxt_o,
    output logic [CNT_W-1:0]  count_o
);

    typedef struct packed {
        act_entry_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]       cnt;
    } stack_t;

    stack_t st_d, st_q;
    logic   hit;

    function automatic logic [PRIO_W:0] top_prio(input act_entry_t [DEPTH-1:0] e,
                                                 input logic [CNT_W-1:0] c);
        logic [PRIO_W:0] p;
        p = IDLE_PRIO;
        for (int i = 0; i < DEPTH; i++) begin
            if (c == CNT_W'(i + 1)) p = {1'b0, e[i].prio};
        end
        return p;
    endfunction

    always_comb begin
        int hit_idx;
        st_d    = st_q;
        hit     = 1'b0;
        hit_idx = 0;
        // most recent matching entry wins: later indices overwrite
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < st_q.cnt && st_q.ent[i].id == eoi_id_i &&
                (!is_sgi(eoi_id_i) || st_q.ent[i].src == eoi_src_i)) begin
                hit     = 1'b1;
                hit_idx = i;
            end
        end
        if (eoi_i && hit) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= hit_idx) st_d.ent[i] = st_q.ent[i+1];
            end
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (push_i && st_d.cnt < CNT_W'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_d.cnt == CNT_W'(i)) st_d.ent[i] = push_entry_i;
            end
            st_d.cnt = st_d.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign eoi_hit_o      = eoi_i && hit;
    assign run_prio_o     = top_prio(st_q.ent, st_q.cnt);
    assign run_prio_nxt_o = top_prio(st_d.ent, st_d.cnt);
    assign full_o         = st_q.cnt == CNT_W'(DEPTH);
    assign full_nxt_o     = st_d.cnt == CNT_W'(DEPTH);
    assign count_o        = st_q.cnt;

endmodule

// File: rtl/cpuif_ack_unit.sv
module cpuif_ack_unit
    import cpuif_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  cand_valid_i,
    input  logic [ID_W-1:0]       cand_id_i,
    input  logic [PRIO_W-1:0]     cand_prio_i,
    input  logic [SRC_W-1:0]      cand_src_i,
    input  logic                  reg_rd_i,
    input  logic                  reg_wr_i,
    input  logic [1:0]            reg_sel_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    output logic                  irq_o,
    output logic                  ack_valid_o,
    output logic [ID_W-1:0]       ack_id_o,
    output logic [SRC_W-1:0]      ack_src_o,
    output logic                  eoi_valid_o,
    output logic [ID_W-1:0]       eoi_id_o,
    output logic [SRC_W-1:0]      eoi_src_o
);

    localparam int CNT_W = $clog2(STACK_DEPTH + 1);

    unit_state_t      st_d, st_q;
    reg_sel_e         sel;
    logic             ok_now, ok_next;
    logic             ack_take, eoi_req, eoi_hit;
    logic [PRIO_W:0]  run_prio, run_prio_nxt;
    logic             full, full_nxt;
    logic [CNT_W-1:0] act_cnt;
    logic             ctrl_en;
    logic [SRC_W-1:0] cand_src_eff;
    logic [ID_W-1:0]  eoi_id_w;
    logic [SRC_W-1:0] eoi_src_w;
    act_entry_t       push_entry;

    assign sel          = reg_sel_e'(reg_sel_i);
    assign cand_src_eff = is_sgi(cand_id_i) ? cand_src_i : '0;
    assign eoi_id_w     = reg_wdata_i[ID_W-1:0];
    assign eoi_src_w    = reg_wdata_i[ID_W +: SRC_W];
    assign ack_take     = reg_rd_i && sel == SEL_ACK && ok_now;
    assign eoi_req      = reg_wr_i && sel == SEL_EOI;
    assign push_entry   = '{id: cand_id_i, src: cand_src_eff, prio: cand_prio_i};
    assign ctrl_en      = st_q.en;

    cpuif_qualify u_qual_now (
        .en_i         (st_q.en),
        .pmask_i      (st_q.pmask),
        .run_prio_i   (run_prio),
        .full_i       (full),
        .cand_valid_i (cand_valid_i),
        .cand_id_i    (cand_id_i),
        .cand_prio_i  (cand_prio_i),
        .signal_o     (ok_now)
    );

    cpuif_qualify u_qual_next (
        .en_i         (st_d.en),
        .pmask_i      (st_d.pmask),
        .run_prio_i   (run_prio_nxt),
        .full_i       (full_nxt),
        .cand_valid_i (cand_valid_i),
        .cand_id_i    (cand_id_i),
        .cand_prio_i  (cand_prio_i),
        .signal_o     (ok_next)
    );

    cpuif_active_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .push_i         (ack_take),
        .push_entry_i   (push_entry),
        .eoi_i          (eoi_req),
        .eoi_id_i       (eoi_id_w),
        .eoi_src_i      (eoi_src_w),
        .eoi_hit_o      (eoi_hit),
        .run_prio_o     (run_prio),
        .run_prio_nxt_o (run_prio_nxt),
        .full_o         (full),
        .full_nxt_o     (full_nxt),
        .count_o        (act_cnt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.ack_v = 1'b0;
        st_d.eoi_v = 1'b0;

        if (reg_wr_i) begin
            case (sel)
                SEL_CTRL:  st_d.en    = reg_wdata_i[0];
                SEL_PMASK: st_d.pmask = reg_wdata_i[PRIO_W-1:0];
                default: ;
            endcase
        end

        if (reg_rd_i) begin
            case (sel)
                SEL_CTRL:  st_d.rdata[0]          = st_q.en;
                SEL_PMASK: st_d.rdata[PRIO_W-1:0] = st_q.pmask;
                SEL_ACK: begin
                    if (ack_take) begin
                        st_d.rdata[ID_W-1:0]    = cand_id_i;
                        st_d.rdata[ID_W+:SRC_W] = cand_src_eff;
                    end else begin
                        st_d.rdata[ID_W-1:0]    = SPURIOUS_ID;
                    end
                end
                default: ;
            endcase
        end

        if (ack_take) begin
            st_d.ack_v   = 1'b1;
            st_d.ack_id  = cand_id_i;
            st_d.ack_src = cand_src_eff;
        end

        if (eoi_hit) begin
            st_d.eoi_v   = 1'b1;
            st_d.eoi_id  = eoi_id_w;
            st_d.eoi_src = is_sgi(eoi_id_w) ? eoi_src_w : '0;
        end

        st_d.irq = ok_next;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign reg_rdata_o = st_q.rdata;
    assign irq_o       = st_q.irq;
    assign ack_valid_o = st_q.ack_v;
    assign ack_id_o    = st_q.ack_id;
    assign ack_src_o   = st_q.ack_src;
    assign eoi_valid_o = st_q.eoi_v;
    assign eoi_id_o    = st_q.eoi_id;
    assign eoi_src_o   = st_q.eoi_src;

endmodule

// File: rtl/cpuif_ack_unit_chk.sv
module cpuif_ack_unit_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             irq_o,
    input logic             ack_valid_o,
    input logic [9:0]       ack_id_o,
    input logic             eoi_valid_o,
    input logic [31:0]      reg_rdata_o,
    input logic             ctrl_en,
    input logic [CNT_W-1:0] act_cnt
);

    // R5: request only while enabled
    a_r5_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ctrl_en);

    // R6: request is low in the cycle of the acknowledge pulse
    a_r6_irq_low_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_valid_o |-> !irq_o);

    // R6: an acknowledge alone adds one active entry
    a_r6_ack_pushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_valid_o && !eoi_valid_o) |-> act_cnt == CNT_W'($past(act_cnt) + 1'b1));

    // R3: acknowledged IDs are never reserved
    a_r3_ack_id_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_valid_o |-> ack_id_o <= 10'd1019);

    // R3: reserved codes other than spurious never reach read data
    a_r3_no_reserved_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rdata_o[9:0] < 10'd1020) || (reg_rdata_o[9:0] == 10'd1023));

    // R7: a retire alone removes one active entry
    a_r7_eoi_pops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_valid_o && !ack_valid_o) |-> act_cnt == CNT_W'($past(act_cnt) - 1'b1));

    // R9: never more active entries than the stack holds
    a_r9_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_cnt <= CNT_W'(DEPTH));

endmodule

bind cpuif_ack_unit cpuif_ack_unit_chk #(.DEPTH(STACK_DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_o       (irq_o),
    .ack_valid_o (ack_valid_o),
    .ack_id_o    (ack_id_o),
    .eoi_valid_o (eoi_valid_o),
    .reg_rdata_o (reg_rdata_o),
    .ctrl_en     (ctrl_en),
    .act_cnt     (act_cnt)
);

// File: tb/cpuif_ack_unit_tb_top.sv
module cpuif_ack_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int RAND_OPS   = 4000;
    localparam int WDOG_CYC   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c_valid = 1'b0;
    logic [9:0]  c_id = '0;
    logic [7:0]  c_pri = '0;
    logic [2:0]  c_src = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [1:0]  sel = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, ack_v, eoi_v;
    logic [9:0]  ack_id, eoi_id;
    logic [2:0]  ack_src, eoi_src;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    // reference model
    bit  m_en;
    int  m_pm;
    int  m_cnt;
    int  m_id[DEPTH];
    int  m_src[DEPTH];
    int  m_pri[DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    cpuif_ack_unit #(.STACK_DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cand_valid_i(c_valid), .cand_id_i(c_id), .cand_prio_i(c_pri), .cand_src_i(c_src),
        .reg_rd_i(rd), .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq),
        .ack_valid_o(ack_v), .ack_id_o(ack_id), .ack_src_o(ack_src),
        .eoi_valid_o(eoi_v), .eoi_id_o(eoi_id), .eoi_src_o(eoi_src)
    );

    function automatic bit m_ok();
        int runp;
        runp = (m_cnt == 0) ? 256 : m_pri[m_cnt-1];
        return m_en && c_valid && int'(c_id) <= 1019 && int'(c_pri) < m_pm &&
               int'(c_pri) < runp && m_cnt < DEPTH;
    endfunction

    task automatic check(input bit good, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!good) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    task automatic set_cand(input bit v, input int id, input int pri, input int src);
        c_valid = v;
        c_id    = 10'(id);
        c_pri   = 8'(pri);
        c_src   = 3'(src);
    endtask

    // one register cycle; called and returns at a falling edge
    task automatic step(input bit r, input bit w, input int s, input int wd, input string req);
        bit   ok;
        bit   exp_ack = 1'b0, exp_eoi = 1'b0;
        int   exp_rd = 0;
        int   exp_aid = 0;
        ok = m_ok();
        if (r) begin
            case (s)
                0: exp_rd = int'(m_en);
                1: exp_rd = m_pm;
                2: begin
                    if (ok) begin
                        int src;
                        src = (int'(c_id) < 16) ? int'(c_src) : 0;
                        exp_rd  = (src << 10) | int'(c_id);
                        exp_ack = 1'b1;
                        exp_aid = int'(c_id);
                        m_id[m_cnt] = int'(c_id); m_src[m_cnt] = src; m_pri[m_cnt] = int'(c_pri);
                        m_cnt++;
                    end else exp_rd = 1023;
                end
                default: exp_rd = 0;
            endcase
        end
        if (w) begin
            case (s)
                0: m_en = wd[0];
                1: m_pm = wd & 8'hff;
                3: begin
                    int eid, esrc;
                    eid  = wd & 10'h3ff;
                    esrc = (wd >> 10) & 7;
                    for (int i = m_cnt - 1; i >= 0; i--) begin
                        if (m_id[i] == eid && (eid >= 16 || m_src[i] == esrc)) begin
                            for (int k = i; k < m_cnt - 1; k++) begin
                                m_id[k] = m_id[k+1]; m_src[k] = m_src[k+1]; m_pri[k] = m_pri[k+1];
                            end
                            m_cnt--;
                            exp_eoi = 1'b1;
                            break;
                        end
                    end
                end
                default: ;
            endcase
        end
        rd = r; wr = w; sel = 2'(s); wdata = 32'(wd);
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
        if (r) check(rdata == 32'(exp_rd), req, "rdata", rdata, exp_rd);
        check(irq == m_ok(), req, "irq", irq, m_ok());
        check(ack_v == exp_ack, req, "ack_valid", ack_v, exp_ack);
        if (exp_ack) check(int'(ack_id) == exp_aid, req, "ack_id", ack_id, exp_aid);
        check(eoi_v == exp_eoi, req, "eoi_valid", eoi_v, exp_eoi);
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        m_en = 1'b0; m_pm = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check(irq == 1'b0 && ack_v == 1'b0 && eoi_v == 1'b0, "R11", "outputs after reset", {irq, ack_v, eoi_v}, 0);
        step(1, 0, 0, 0, "R11 ctrl");
        step(1, 0, 1, 0, "R11 pmask");
        // R5 R2: disabled, spurious
        set_cand(1, 40, 8'h30, 0);
        step(1, 0, 2, 0, "R5 disabled ack");
        step(0, 1, 0, 1, "R10 enable");
        step(1, 0, 0, 0, "R10 ctrl readback");
        // R4: mask boundary
        step(1, 0, 2, 0, "R4 mask zero");
        step(0, 1, 1, 8'h30, "R4 equal to mask");
        step(0, 1, 1, 8'h31, "R4 one below mask");
        step(1, 0, 1, 0, "R10 pmask readback");
        // R5: disable drops line
        step(0, 1, 0, 0, "R5 disable");
        step(1, 0, 2, 0, "R5 ack while disabled");
        step(0, 1, 0, 1, "R5 reenable");
        // R3: reserved IDs
        step(0, 1, 1, 8'hff, "R3 open mask");
        set_cand(1, 1020, 0, 0);
        step(1, 0, 2, 0, "R3 id 1020");
        set_cand(1, 1023, 0, 0);
        step(1, 0, 2, 0, "R3 id 1023");
        // R6: acknowledge and running priority
        set_cand(1, 40, 8'h30, 0);
        step(0, 0, 0, 0, "R6 idle");
        step(1, 0, 2, 0, "R6 ack 40");
        set_cand(1, 50, 8'h30, 0);
        step(0, 0, 0, 0, "R6 equal running");
        set_cand(1, 50, 8'h20, 0);
        step(0, 0, 0, 0, "R6 preempt");
        step(1, 0, 2, 0, "R6 ack 50");
        // R1: software-generated ID packs source
        set_cand(1, 5, 8'h10, 6);
        step(1, 0, 2, 0, "R1 sgi ack");
        set_cand(1, 60, 8'h18, 0);
        step(0, 0, 0, 0, "R6 blocked by 0x10");
        // R8: unmatched retires
        step(0, 1, 3, 99, "R8 eoi inactive id");
        step(0, 1, 3, (2 << 10) | 5, "R8 eoi wrong src");
        // R7: matching retire
        step(0, 1, 3, (6 << 10) | 5, "R7 eoi sgi");
        step(1, 0, 2, 0, "R7 ack after retire");
        // R9: stack full
        set_cand(1, 70, 8'h05, 0);
        step(1, 0, 2, 0, "R9 fill");
        set_cand(1, 71, 8'h01, 0);
        step(1, 0, 2, 0, "R9 full no ack");
        step(0, 1, 3, 40, "R7 eoi deep entry");
        step(1, 0, 2, 0, "R9 ack after room");
        step(1, 0, 3, 0, "R10 eoi reads zero");
        // drain
        for (int i = 0; i < DEPTH + 2; i++) begin
            int wd;
            wd = (m_cnt > 0) ? ((m_src[m_cnt-1] << 10) | m_id[m_cnt-1]) : 0;
            step(0, 1, 3, wd, "R7 drain");
        end

        // seeded random phase
        for (int n = 0; n < RAND_OPS; n++) begin
            int kind, pick;
            kind = $urandom_range(99);
            pick = $urandom_range(19);
            if (pick < 4)       set_cand($urandom_range(9) != 0, $urandom_range(15), $urandom_range(255), $urandom_range(7));
            else if (pick == 4) set_cand(1, 1020 + $urandom_range(3), $urandom_range(255), 0);
            else if (pick < 12) set_cand($urandom_range(9) != 0, 16 + $urandom_range(1003), $urandom_range(255), $urandom_range(7));
            if (kind < 40) begin
                step(1, 0, 2, 0, "R6 random ack");
            end else if (kind < 65) begin
                int wd;
                if (m_cnt > 0 && $urandom_range(9) < 7) begin
                    int k;
                    k  = $urandom_range(m_cnt - 1);
                    wd = (m_src[k] << 10) | m_id[k];
                end else wd = $urandom_range(8191);
                step(0, 1, 3, wd, "R7 random eoi");
            end else if (kind < 75) begin
                step(0, 1, 1, $urandom_range(255), "R4 random mask");
            end else if (kind < 80) begin
                step(0, 1, 0, ($urandom_range(4) != 0) ? 1 : 0, "R5 random ctrl");
            end else if (kind < 88) begin
                step(1, 0, $urandom_range(1), 0, "R10 random read");
            end else begin
                step(0, 0, 0, 0, "R6 random idle");
            end
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule